// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execute stage of a 32-bit load/store core. Each clock it takes two operands, an operation code, a flag-update enable, the current status word and the carry produced by the operand shifter. It registers three results: the 32-bit value, a destination write enable and the next status word. The shifter sits outside the block; the second operand arrives already shifted, together with the shifter's carry and a marker saying the operand was a rotated immediate.

Operations come in four flag classes. The add class is ADD, ADC and CMN. The subtract class is SUB, SBC and CMP. The reverse-subtract class is RSB and RSC. The logic class covers the bitwise operations, the moves, TST, TEQ and MOVT. Carry and overflow follow the class of the operation. The compare and test operations update only the flags.

Top module: `dp_alu`

## Requirements
- R1: When flags are updated, status bit 31 takes N, bit 30 takes Z, bit 29 takes C and bit 28 takes V. Status bits 27:0 always pass through from `status_in` unchanged.
- R2: N equals bit 31 of the result. Z is 1 exactly when the whole 32-bit result is zero. For a compare or test operation, the result is the value the operation computes internally.
- R3: Add class (codes ADD=4, ADC=5, CMN=11) computes A+B+cin. cin is 0, except for ADC, where it is the old C (status bit 29). C is the carry out of bit 31. V is the signed overflow of that sum.
- R4: Subtract class (codes SUB=2, SBC=6, CMP=10) computes A+~B+cin. cin is 1, except for SBC, where it is the old C. C and V come from that addition.
- R5: Reverse-subtract class (codes RSB=3, RSC=7) computes B+~A+cin. cin is 1, except for RSC, where it is the old C. C and V come from that addition.
- R6: Logic results are AND=0 (A&B), EOR=1 (A^B), ORR=12 (A|B), MOV=13 (B), BIC=14 (A&~B), MVN=15 (~B) and ORN=16 (A|~B).
- R7: For logic-class operations (R6 codes, TST, TEQ, MOVT), C is bit 31 of B when `imm_rotated` is 1 and `shift_carry` otherwise. V keeps its old value.
- R8: TST=8 computes A&B, TEQ=9 computes A^B, CMP computes as SUB and CMN computes as ADD. All four drive `dest_we` low. Every other known code drives `dest_we` high.
- R9: MOVT=17 returns {B[15:0], A[15:0]}.
- R10: When `set_flags` is 0, `status_out` equals `status_in`.
- R11: Outputs are registered and show the inputs from the previous rising clock edge. While `rst_n` is low, all outputs are zero.
- R12: Codes 18 to 31 produce result 0 and `dest_we` 0, and pass `status_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 5 | Operation code (see R3 to R9, R12) |
| set_flags | input | 1 | Update N/Z/C/V when 1 |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Carry out of the operand shifter |
| imm_rotated | input | 1 | Second operand is a rotated immediate |
| status_in | input | 32 | Current status word |
| result | output | 32 | Registered result |
| dest_we | output | 1 | Registered destination write enable |
| status_out | output | 32 | Registered next status word |

## Verification
A compare or test operation with flag update enabled raises two things in the same cycle: a status rewrite and a suppressed destination write. The bench issues CMP, CMN, TST and TEQ with `set_flags` high. It judges the `dest_we` drop separately from the N/Z/C/V check. The logic class also has a carry-source choice that can collide: a rotated immediate whose bit 31 differs from `shift_carry`. The vectors toggle both inputs against each other, so a wrong choice shows in bit 29. The carry-in operations run with each value of the old C bit.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  localparam logic [4:0] OP_AND  = 5'd0;
  localparam logic [4:0] OP_EOR  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_RSB  = 5'd3;
  localparam logic [4:0] OP_ADD  = 5'd4;
  localparam logic [4:0] OP_ADC  = 5'd5;
  localparam logic [4:0] OP_SBC  = 5'd6;
  localparam logic [4:0] OP_RSC  = 5'd7;
  localparam logic [4:0] OP_TST  = 5'd8;
  localparam logic [4:0] OP_TEQ  = 5'd9;
  localparam logic [4:0] OP_CMP  = 5'd10;
  localparam logic [4:0] OP_CMN  = 5'd11;
  localparam logic [4:0] OP_ORR  = 5'd12;
  localparam logic [4:0] OP_MOV  = 5'd13;
  localparam logic [4:0] OP_BIC  = 5'd14;
  localparam logic [4:0] OP_MVN  = 5'd15;
  localparam logic [4:0] OP_ORN  = 5'd16;
  localparam logic [4:0] OP_MOVT = 5'd17;
  localparam logic [4:0] OP_LAST = OP_MOVT;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ADD   = 2'd1,
    CLS_SUB   = 2'd2,
    CLS_RSB   = 2'd3
  } op_class_e;

  function automatic op_class_e op_class(input logic [4:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_CMN: op_class = CLS_ADD;
      OP_SUB, OP_SBC, OP_CMP: op_class = CLS_SUB;
      OP_RSB, OP_RSC:         op_class = CLS_RSB;
      default:                op_class = CLS_LOGIC;
    endcase
  endfunction

  function automatic logic op_is_compare(input logic [4:0] op);
    op_is_compare = (op == OP_TST) || (op == OP_TEQ) ||
                    (op == OP_CMP) || (op == OP_CMN);
  endfunction

  function automatic logic op_is_known(input logic [4:0] op);
    op_is_known = (op <= OP_LAST);
  endfunction

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);

  localparam int unsigned HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] bitwise_op(
    input logic [4:0] code, input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    case (code)
      OP_AND, OP_TST: bitwise_op = x & y;
      OP_EOR, OP_TEQ: bitwise_op = x ^ y;
      OP_ORR:         bitwise_op = x | y;
      OP_MOV:         bitwise_op = y;
      OP_BIC:         bitwise_op = x & ~y;
      OP_MVN:         bitwise_op = ~y;
      OP_ORN:         bitwise_op = x | ~y;
      OP_MOVT:        bitwise_op = {y[HALF_W-1:0], x[HALF_W-1:0]};
      default:        bitwise_op = '0;
    endcase
  endfunction

  assign res = bitwise_op(op, a, b);

endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              old_c,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              v_out
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] add_x;
  logic [DATA_W-1:0] add_y;
  logic              add_cin;
  logic [DATA_W:0]   add_sum;

  function automatic logic [DATA_W:0] wide_add(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y, input logic cin);
    wide_add = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  endfunction

  always_comb begin
    add_x   = a;
    add_y   = b;
    add_cin = 1'b0;
    case (op)
      OP_ADC: add_cin = old_c;
      OP_SUB, OP_CMP: begin add_y = ~b; add_cin = 1'b1; end
      OP_SBC: begin add_y = ~b; add_cin = old_c; end
      OP_RSB: begin add_x = b; add_y = ~a; add_cin = 1'b1; end
      OP_RSC: begin add_x = b; add_y = ~a; add_cin = old_c; end
      default: ;
    endcase
  end

  assign add_sum = wide_add(add_x, add_y, add_cin);
  assign res     = add_sum[MSB:0];
  assign c_out   = add_sum[DATA_W];
  assign v_out   = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 32
) (
  input  logic              flags_go,
  input  op_class_e         cls,
  input  logic [DATA_W-1:0] res,
  input  logic              arith_c,
  input  logic              arith_v,
  input  logic              logic_c,
  input  logic [STAT_W-1:0] status_in,
  output logic [STAT_W-1:0] status_next
);

  localparam int unsigned N_POS = STAT_W - 1;
  localparam int unsigned Z_POS = STAT_W - 2;
  localparam int unsigned C_POS = STAT_W - 3;
  localparam int unsigned V_POS = STAT_W - 4;

  always_comb begin
    status_next = status_in;
    if (flags_go) begin
      status_next[N_POS] = res[DATA_W-1];
      status_next[Z_POS] = (res == '0);
      if (cls == CLS_LOGIC) begin
        status_next[C_POS] = logic_c;
      end else begin
        status_next[C_POS] = arith_c;
        status_next[V_POS] = arith_v;
      end
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        opcode,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              shift_carry,
  input  logic              imm_rotated,
  input  logic [STAT_W-1:0] status_in,
  output logic [DATA_W-1:0] result,
  output logic              dest_we,
  output logic [STAT_W-1:0] status_out
);

  localparam int unsigned C_POS = STAT_W - 3;

  op_class_e         cls_w;
  logic              known_w;
  logic              is_cmp_w;
  logic              flags_go_w;
  logic              logic_c_w;
  logic              arith_c_w;
  logic              arith_v_w;
  logic [DATA_W-1:0] logic_res_w;
  logic [DATA_W-1:0] arith_res_w;
  logic [DATA_W-1:0] res_next;
  logic [STAT_W-1:0] status_next;
  logic              we_next;

  assign cls_w      = op_class(opcode);
  assign known_w    = op_is_known(opcode);
  assign is_cmp_w   = op_is_compare(opcode);
  assign flags_go_w = set_flags && known_w;
  assign logic_c_w  = imm_rotated ? op_b[DATA_W-1] : shift_carry;

  dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op  (opcode),
    .a   (op_a),
    .b   (op_b),
    .res (logic_res_w)
  );

  dp_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op    (opcode),
    .a     (op_a),
    .b     (op_b),
    .old_c (status_in[C_POS]),
    .res   (arith_res_w),
    .c_out (arith_c_w),
    .v_out (arith_v_w)
  );

  always_comb begin
    if (!known_w)                res_next = '0;
    else if (cls_w == CLS_LOGIC) res_next = logic_res_w;
    else                         res_next = arith_res_w;
  end

  assign we_next = known_w && !is_cmp_w;

  dp_alu_flags #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_flags (
    .flags_go    (flags_go_w),
    .cls         (cls_w),
    .res         (res_next),
    .arith_c     (arith_c_w),
    .arith_v     (arith_v_w),
    .logic_c     (logic_c_w),
    .status_in   (status_in),
    .status_next (status_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      dest_we    <= 1'b0;
      status_out <= '0;
    end else begin
      result     <= res_next;
      dest_we    <= we_next;
      status_out <= status_next;
    end
  end

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
  import dp_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        opcode,
  input logic              set_flags,
  input logic [DATA_W-1:0] op_a,
  input logic [STAT_W-1:0] status_in,
  input logic [DATA_W-1:0] result,
  input logic              dest_we,
  input logic [STAT_W-1:0] status_out,
  input logic              flags_go_w,
  input logic              is_cmp_w,
  input op_class_e         cls_w
);

  localparam int unsigned HALF_W = DATA_W / 2;

  p_low_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> status_out[STAT_W-5:0] == $past(status_in[STAT_W-5:0]));

  p_nz_from_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && flags_go_w) |=>
      (status_out[STAT_W-1] == result[DATA_W-1]) &&
      (status_out[STAT_W-2] == (result == '0)));

  p_logic_v_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && flags_go_w && cls_w == CLS_LOGIC) |=>
      status_out[STAT_W-4] == $past(status_in[STAT_W-4]));

  p_cmp_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && is_cmp_w) |=> !dest_we);

  p_movt_low_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && opcode == OP_MOVT) |=> result[HALF_W-1:0] == $past(op_a[HALF_W-1:0]));

  p_hold_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !set_flags) |=> status_out == $past(status_in));

endmodule

bind dp_alu dp_alu_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_dp_alu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opcode     (opcode),
  .set_flags  (set_flags),
  .op_a       (op_a),
  .status_in  (status_in),
  .result     (result),
  .dest_we    (dest_we),
  .status_out (status_out),
  .flags_go_w (flags_go_w),
  .is_cmp_w   (is_cmp_w),
  .cls_w      (cls_w)
);

// File: tb/test_dp_alu.sv
module test_dp_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        shift_carry = 1'b0;
  logic        imm_rotated = 1'b0;
  logic [31:0] status_in = '0;
  logic [31:0] result;
  logic        dest_we;
  logic [31:0] status_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [31:0] st;
    logic [4:0]  op;
    logic        sf;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu i_dp_alu (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .set_flags(set_flags),
    .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry),
    .imm_rotated(imm_rotated), .status_in(status_in),
    .result(result), .dest_we(dest_we), .status_out(status_out)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string res_tag(input logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd12, 5'd13, 5'd14, 5'd15, 5'd16: res_tag = "R6";
      5'd2, 5'd6:  res_tag = "R4";
      5'd3, 5'd7:  res_tag = "R5";
      5'd4, 5'd5:  res_tag = "R3";
      5'd8, 5'd9, 5'd10, 5'd11: res_tag = "R8";
      5'd17: res_tag = "R9";
      default: res_tag = "R12";
    endcase
  endfunction

  function automatic string cv_tag(input logic [4:0] op);
    case (op)
      5'd4, 5'd5, 5'd11: cv_tag = "R3";
      5'd2, 5'd6, 5'd10: cv_tag = "R4";
      5'd3, 5'd7:        cv_tag = "R5";
      default:           cv_tag = "R7";
    endcase
  endfunction

  // Reference: arithmetic through 33-bit sums and signed 64-bit overflow test.
  function automatic exp_t model(input logic [4:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic sc, input logic rot, input logic sf,
      input logic [31:0] st);
    exp_t e;
    logic [31:0] x, y, r;
    logic ci, arith, c, v;
    logic [32:0] s33;
    longint ss;
    e.op = op; e.sf = sf; e.st = st;
    e.we = (op <= 5'd17) && !(op >= 5'd8 && op <= 5'd11);
    arith = 1'b1; x = a; y = b; ci = 1'b0; r = '0;
    case (op)
      5'd4, 5'd11: ;
      5'd5:        ci = st[29];
      5'd2, 5'd10: begin y = ~b; ci = 1'b1; end
      5'd6:        begin y = ~b; ci = st[29]; end
      5'd3:        begin x = b; y = ~a; ci = 1'b1; end
      5'd7:        begin x = b; y = ~a; ci = st[29]; end
      default:     arith = 1'b0;
    endcase
    s33 = {1'b0, x} + {1'b0, y} + {32'd0, ci};
    ss = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
    v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    c = s33[32];
    if (arith) r = s33[31:0];
    else begin
      case (op)
        5'd0, 5'd8:  r = a & b;
        5'd1, 5'd9:  r = a ^ b;
        5'd12:       r = a | b;
        5'd13:       r = b;
        5'd14:       r = a & ~b;
        5'd15:       r = ~b;
        5'd16:       r = a | ~b;
        5'd17:       r = {b[15:0], a[15:0]};
        default:     r = '0;
      endcase
      c = rot ? b[31] : sc;
      v = st[28];
    end
    e.res = r;
    if (sf && op <= 5'd17) begin
      e.st[31] = r[31];
      e.st[30] = (r == 32'd0);
      e.st[29] = c;
      e.st[28] = v;
    end
    return e;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic sc, input logic rot, input logic sf,
      input logic [31:0] st);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; shift_carry = sc;
    imm_rotated = rot; set_flags = sf; status_in = st;
    sb_q.push_back(model(op, a, b, sc, rot, sf, st));
  endtask

  // Monitor: registered outputs appear after the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(res_tag(e.op), "result", result, e.res);
        check("R8", "dest_we", {31'd0, dest_we}, {31'd0, e.we});
        if (e.op > 5'd17)
          check("R12", "status", status_out, e.st);
        else if (!e.sf)
          check("R10", "status", status_out, e.st);
        else begin
          check("R2", "NZ", {30'd0, status_out[31:30]}, {30'd0, e.st[31:30]});
          check(cv_tag(e.op), "CV", {30'd0, status_out[29:28]}, {30'd0, e.st[29:28]});
          check("R1", "low", {4'd0, status_out[27:0]}, {4'd0, e.st[27:0]});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [6];
    int n;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h0000_FFFF;
    status_in = 32'h5A5A_5A5A;
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset result", result, 32'd0);
    check("R11", "reset dest_we", {31'd0, dest_we}, 32'd0);
    check("R11", "reset status", status_out, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int op = 0; op < 18; op++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          for (int sf = 0; sf < 2; sf++) begin
            logic [31:0] st;
            st = $urandom();
            st[29] = n[0];
            st[28] = n[2];
            drive(5'(op), vals[i], vals[j], n[1], n[3], sf[0], st);
            n++;
          end
        end
      end
    end
    for (int k = 0; k < 2000; k++) begin
      drive(5'($urandom() % 20), $urandom(), $urandom(), 1'($urandom()),
            1'($urandom()), 1'($urandom()), $urandom());
    end
    for (int op = 18; op < 32; op++)
      drive(5'(op), 32'h1234_5678, 32'h8765_4321, 1'b1, 1'b0, 1'b1, 32'hF0F0_0F0F);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule